// File: doc/BRIEF.md
# Dual-Port Burst-of-Two Double-Data-Rate SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It has a separate read port and a separate write port, and each access moves a burst of two 18-bit words. Both ports may start an access on the same rising clock edge. Each port has its own active-low select and its own address. The second word of a burst always goes to the partner address, which differs from the first only in the least significant bit. Bursts therefore never leave an aligned pair of words.

Write data moves on both clock edges. The first word and its two active-low lane enables are captured on the rising edge that starts the write. The second word and its own lane enables are captured on the falling edge that follows. Read data also moves on both edges. During the whole clock cycle after the request, `rd_drive` is high. The first word is presented in the high phase and the partner word in the low phase. The same clock stands in for the output clock pair. A low `rd_drive` stands for high impedance, and `rd_data` is held at zero while it is low.

The read sequencer is a four-state machine on the rising edge. Its state records two things: whether a request is waiting from the previous edge (ARMED) and whether a burst is being driven in the current cycle (SEND).

| State | Meaning |
|---|---|
| RS_IDLE | no request waiting, nothing driven |
| RS_ARMED | request captured, nothing driven yet |
| RS_SEND | burst driven, no new request |
| RS_SEND_ARMED | burst driven while the next request is captured |

The transitions, taken on each rising edge with `req = !rd_sel_n`, are as follows:

| From | req = 0 | req = 1 |
|---|---|---|
| RS_IDLE | RS_IDLE | RS_ARMED |
| RS_SEND | RS_IDLE | RS_ARMED |
| RS_ARMED | RS_SEND | RS_SEND_ARMED |
| RS_SEND_ARMED | RS_SEND | RS_SEND_ARMED |

Reset forces RS_IDLE.

Top module: `ddr_burst_sram`

## Requirements
- R1: After reset, `rd_drive` is low and `rd_data` is zero.
- R2: A write requested at a rising edge (`wr_sel_n` low) stores the word on `wr_data` at that edge into `wr_addr`. It stores the word present at the next falling edge into `wr_addr` with bit 0 inverted.
- R3: A read requested at rising edge t (`rd_sel_n` low) drives `rd_drive` high from edge t+1 to edge t+2. During the high phase `rd_data` carries word `rd_addr`. During the low phase it carries word `rd_addr` with bit 0 inverted.
- R4: Whenever `rd_drive` is low, `rd_data` is all zeros.
- R5: A cycle with both selects high changes no stored word, whatever `wr_data` and `wr_lane_n` carry. The following cycle drives nothing.
- R6: `wr_lane_n` is active low. Bit 0 enables bits [8:0] and bit 1 enables bits [17:9]. A lane whose enable is high keeps its stored bits, and `2'b11` writes nothing.
- R7: The lane enables are sampled separately for each word, on the same edge as that word's data, so the two words of one burst may use different masks.
- R8: A read and a write may start on the same rising edge at any addresses. A read started at edge t returns data that includes the write started at edge t, but not a write started at edge t+1.
- R9: Reads requested on consecutive rising edges keep `rd_drive` high without a gap, each cycle carrying its own burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock; rising edge starts accesses, falling edge takes the second write word |
| rst_n | input | 1 | asynchronous active-low reset |
| rd_sel_n | input | 1 | active-low read request, sampled on the rising edge |
| rd_addr | input | ADDR_W | read burst start address |
| wr_sel_n | input | 1 | active-low write request, sampled on the rising edge |
| wr_addr | input | ADDR_W | write burst start address |
| wr_data | input | DATA_W | write word: first word at the rising edge, second at the falling edge |
| wr_lane_n | input | LANES | active-low lane enables for the word on `wr_data` |
| rd_data | output | DATA_W | read word: first word in the high phase, partner word in the low phase |
| rd_drive | output | 1 | high while a read burst is driven; low means high impedance |

## Verification
The assertions check three things on every rising edge: that `rd_drive` follows the read select two edges earlier, that an idle cycle after both selects are high drives nothing, and that `rd_data` is zero whenever nothing is driven, on both edges. The stored contents are visible only through reads, so only the bench's scenarios can show the correct values. These cover the address-pair inversion, the per-word lane masks, same-cycle read-after-write ordering and the immunity of memory to no-op cycles. The bench compares every returned word against its own reference array.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;
    // Read sequencer: bit 1 = a burst is driven this cycle, bit 0 = a request is waiting
    typedef enum logic [1:0] {
        RS_IDLE       = 2'b00,
        RS_ARMED      = 2'b01,
        RS_SEND       = 2'b10,
        RS_SEND_ARMED = 2'b11
    } rd_state_t;
endpackage

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lane_n,
    output logic              go_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] word0_q,
    output logic [LANES-1:0]  mask0_q
);
    // First beat and burst address are taken on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            addr_q  <= '0;
            word0_q <= '0;
            mask0_q <= '1;
        end else begin
            go_q    <= !wr_sel_n;
            addr_q  <= wr_addr;
            word0_q <= wr_data;
            mask0_q <= wr_lane_n;
        end
    end
endmodule

// File: rtl/ddr_store.sv
module ddr_store #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 18,
    parameter int LANES  = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LANE_W = DATA_W / LANES
) (
    input  logic              clk,
    input  logic              commit,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] word0,
    input  logic [LANES-1:0]  mask0,
    input  logic [DATA_W-1:0] word1,
    input  logic [LANES-1:0]  mask1,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword0,
    output logic [DATA_W-1:0] rword1
);
    logic [ADDR_W-1:0] waddr_pair;
    logic [ADDR_W-1:0] raddr_pair;

    assign waddr_pair = waddr ^ ADDR_W'(1);
    assign raddr_pair = raddr ^ ADDR_W'(1);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Both beats commit on the falling edge, when the second beat is present
        always_ff @(negedge clk) begin
            if (commit) begin
                if (!mask0[l]) cells[waddr]      <= word0[l*LANE_W +: LANE_W];
                if (!mask1[l]) cells[waddr_pair] <= word1[l*LANE_W +: LANE_W];
            end
        end

        assign rword0[l*LANE_W +: LANE_W] = cells[raddr];
        assign rword1[l*LANE_W +: LANE_W] = cells[raddr_pair];
    end
endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq
    import ddr_burst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rword0,
    input  logic [DATA_W-1:0] rword1,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    rd_state_t         state, state_nx;
    logic [DATA_W-1:0] beat0_q, beat1_q;
    logic              rise_tgl, fall_tgl;
    logic              low_phase;

    always_comb begin
        unique case (state)
            RS_IDLE, RS_SEND:
                state_nx = rd_sel_n ? RS_IDLE : RS_ARMED;
            RS_ARMED, RS_SEND_ARMED:
                state_nx = rd_sel_n ? RS_SEND : RS_SEND_ARMED;
            default:
                state_nx = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RS_IDLE;
            addr_q   <= '0;
            beat0_q  <= '0;
            beat1_q  <= '0;
            rise_tgl <= 1'b0;
        end else begin
            state    <= state_nx;
            rise_tgl <= !rise_tgl;
            if (!rd_sel_n) addr_q <= rd_addr;
            // Words are taken one edge after the request, after the falling-edge commit
            if (state == RS_ARMED || state == RS_SEND_ARMED) begin
                beat0_q <= rword0;
                beat1_q <= rword1;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_tgl <= 1'b0;
        else        fall_tgl <= rise_tgl;
    end

    // Toggles differ after a rising edge and agree after a falling edge
    assign low_phase = (rise_tgl == fall_tgl);

    always_comb begin
        unique case (state)
            RS_SEND, RS_SEND_ARMED: begin
                rd_drive = 1'b1;
                rd_data  = low_phase ? beat1_q : beat0_q;
            end
            default: begin
                rd_drive = 1'b0;
                rd_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 18,
    parameter int LANES  = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lane_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_word0;
    logic [LANES-1:0]  wr_mask0;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [DATA_W-1:0] rword0, rword1;

    ddr_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel_n  (wr_sel_n),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_lane_n (wr_lane_n),
        .go_q      (wr_go),
        .addr_q    (wr_addr_q),
        .word0_q   (wr_word0),
        .mask0_q   (wr_mask0)
    );

    ddr_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LANES(LANES)) i_store (
        .clk    (clk),
        .commit (wr_go),
        .waddr  (wr_addr_q),
        .word0  (wr_word0),
        .mask0  (wr_mask0),
        .word1  (wr_data),
        .mask1  (wr_lane_n),
        .raddr  (rd_addr_q),
        .rword0 (rword0),
        .rword1 (rword1)
    );

    ddr_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel_n (rd_sel_n),
        .rd_addr  (rd_addr),
        .rword0   (rword0),
        .rword1   (rword1),
        .addr_q   (rd_addr_q),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );
endmodule

// File: rtl/ddr_burst_sram_chk.sv
module ddr_burst_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_sel_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_drive
);
    logic [1:0] warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R3
    drive_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (rd_drive == !$past(rd_sel_n, 2)));

    // R5
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm >= 2'd2) && $past(rd_sel_n, 2)) |-> !rd_drive);

    // R4
    idle_zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

    // R4
    idle_zero_fall_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));
endmodule

bind ddr_burst_sram ddr_burst_sram_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel_n (rd_sel_n),
    .rd_data  (rd_data),
    .rd_drive (rd_drive)
);

// File: tb/test_ddr_burst_sram.sv
module test_ddr_burst_sram;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int DW    = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_sel_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    wr_lane_n = 2'b11;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic          pend = 1'b0;
    logic [DW-1:0] exp0 = '0, exp1 = '0;
    string         tag = "R3";

    always #10 clk = !clk;

    ddr_burst_sram i_ddr_burst_sram (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_lane_n(wr_lane_n), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 613 + k * 97 + 11) & 32'h3ffff);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] d,
                                            input logic [1:0] m);
        logic [DW-1:0] r = old;
        if (!m[0]) r[8:0]  = d[8:0];
        if (!m[1]) r[17:9] = d[17:9];
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: control and first beat at the rising edge, second beat at the falling edge
    task automatic step(input logic rn, input int ra, input logic wn, input int wa,
                        input logic [DW-1:0] d0, input logic [1:0] m0,
                        input logic [DW-1:0] d1, input logic [1:0] m1);
        rd_sel_n = rn; rd_addr = AW'(ra);
        wr_sel_n = wn; wr_addr = AW'(wa);
        wr_data = d0; wr_lane_n = m0;
        @(posedge clk); #5;
        chk(rd_drive == pend, "R3/R9 drive high phase", DW'(rd_drive), DW'(pend));
        if (pend) chk(rd_data == exp0, tag, rd_data, exp0);
        else      chk(rd_data == '0, "R4 idle high phase", rd_data, '0);
        wr_data = d1; wr_lane_n = m1;
        rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        rd_addr = ~rd_addr; wr_addr = ~wr_addr;
        @(negedge clk); #5;
        chk(rd_drive == pend, "R3/R9 drive low phase", DW'(rd_drive), DW'(pend));
        if (pend) chk(rd_data == exp1, tag, rd_data, exp1);
        else      chk(rd_data == '0, "R4 idle low phase", rd_data, '0);
        if (!wn) begin
            ref_mem[wa]     = merge(ref_mem[wa], d0, m0);
            ref_mem[wa ^ 1] = merge(ref_mem[wa ^ 1], d1, m1);
        end
        pend = !rn;
        if (!rn) begin
            exp0 = ref_mem[ra];
            exp1 = ref_mem[ra ^ 1];
        end
    endtask

    task automatic idle();
        step(1'b1, 0, 1'b1, 0, '0, 2'b11, '0, 2'b11);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #5;
        // R1: reset state while reset is held
        chk(rd_drive == 1'b0, "R1 drive", DW'(rd_drive), '0);
        chk(rd_data == '0, "R1 data", rd_data, '0);
        rst_n = 1'b1;

        // R2: fill every word with full writes; some bursts start at odd addresses
        tag = "R2";
        for (int a = 0; a < DEPTH; a += 2) begin
            int wa = a + ((a >> 1) & 1);
            step(1'b1, 0, 1'b0, wa, pat(wa, 0), 2'b00, pat(wa ^ 1, 0), 2'b00);
        end
        // R3/R9: back-to-back reads over the whole array
        tag = "R3 R9 readback";
        for (int a = 0; a < DEPTH; a++) step(1'b0, a, 1'b1, 0, '0, 2'b11, '0, 2'b11);
        idle();

        // R6/R7: every pair of per-beat lane masks
        tag = "R6 R7 lane masks";
        for (int m0 = 0; m0 < 4; m0++) begin
            for (int m1 = 0; m1 < 4; m1++) begin
                int wa = (m0 * 4 + m1) * 2 + (m1 & 1);
                step(1'b1, 0, 1'b0, wa, pat(wa, 5), 2'(m0), pat(wa, 9), 2'(m1));
                step(1'b0, wa, 1'b1, 0, '0, 2'b11, '0, 2'b11);
            end
        end
        idle();

        // R5: no-op cycles with busy data lines, then read back
        tag = "R5 nop keeps memory";
        for (int i = 0; i < 8; i++)
            step(1'b1, i, 1'b1, i * 2, pat(i, 3), 2'b00, pat(i, 4), 2'b00);
        for (int i = 0; i < 8; i++) step(1'b0, i * 2, 1'b1, 0, '0, 2'b11, '0, 2'b11);
        idle();

        // R8: read and write at the same address in the same cycle, then a write one cycle later
        tag = "R8 same-cycle order";
        for (int i = 0; i < 6; i++) begin
            int a = 40 + i * 3;
            step(1'b0, a, 1'b0, a, pat(a, 20), 2'(i & 3), pat(a, 21), 2'b00);
            step(1'b0, a ^ 1, 1'b0, a, pat(a, 22), 2'b00, pat(a, 23), 2'(i & 2));
            step(1'b1, 0, 1'b0, a ^ 1, pat(a, 24), 2'b01, pat(a, 25), 2'b10);
        end
        idle();

        // R4/R9: reads separated by gaps of various lengths
        tag = "R4 R9 gapped reads";
        for (int g = 0; g < 4; g++) begin
            step(1'b0, g * 7, 1'b1, 0, '0, 2'b11, '0, 2'b11);
            step(1'b0, g * 7 + 1, 1'b0, 200 + g, pat(g, 30), 2'b00, pat(g, 31), 2'b00);
            for (int k = 0; k < g; k++) idle();
        end
        idle();
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule